// File: doc/BRIEF.md
# Bicolor LED Error Code Flasher

This block shows a 32-bit fault signature on two indicator LEDs, one red and one green. A signature is a 32-bit word in which the bits at even positions form the green stream and the bits at odd positions form the red stream. The block steps through the word two bits at a time. A single word can therefore give each colour its own slow, fast, solid or dark blink pattern. The pattern repeats every 16 steps.

After reset the block is dark and waits. A one-cycle load strobe captures a signature and starts the flasher. The signature is either the 32-bit word on the code input or one of nine built-in fault codes chosen by a 4-bit index. From then on the block runs until reset. Any later load strobe has no effect.

Each step lasts a programmable number of clock cycles. At 100 MHz the default gives one eighth of a second, so a full cycle of the pattern takes two seconds. On each step the LEDs take the two lowest bits of the rotating register, and the register rotates right by two positions.

Top module: `errcode_flasher`

## Requirements
- R1: During and directly after reset, both LED outputs are 0.
- R2: Until a load strobe is seen, both LEDs stay 0 and no stepping happens, however many step periods pass.
- R3: When the index is 0 or in the range 10 to 15, a load captures the 32-bit code input unchanged.
- R4: Index values 1 to 9 select built-in codes, one each in this order: 0xffff0000, 0xaaaa5555, 0xaaaa0000, 0x00005555, 0xffffaaaa, 0xffff5555, 0xeeee4444, 0xdddd8888, 0xddddcccc.
- R5: On each step, green takes bit 0 and red takes bit 1 of the register as it stood before that step.
- R6: Each step rotates the register right by two bits, so step k (counting from 0) shows bits 2k and 2k+1 of the loaded code.
- R7: The first step happens on the clock edge TICK_CYCLES cycles after the load edge. Later steps follow every TICK_CYCLES cycles. Between steps the LEDs hold their value.
- R8: The LED sequence repeats with a period of 16 steps.
- R9: Once running, further load strobes are ignored, whatever code or index comes with them. The sequence carries on unchanged, and only reset stops it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | One-cycle strobe that captures a code and starts flashing |
| err_idx_i | input | 4 | Built-in code index (1..9); other values select code_i |
| code_i | input | 32 | Raw signature used when the index selects no built-in code |
| led_red_o | output | 1 | Red LED enable |
| led_green_o | output | 1 | Green LED enable |

## Verification
The raw code 0x9c3e5a71 has a different two-bit pair in most steps. This tells apart a rotation by two from a rotation by one, and shows whether the red and green streams are swapped. Each of the nine built-in codes is loaded after its own reset and followed for a full 32 steps. This shows that each index maps to the right constant and that the pattern wraps after 16 steps. A code whose lowest pair is 11 shows whether the first step lands exactly TICK_CYCLES cycles after the load. A second load with a different code in the middle of a run must leave the sequence undisturbed. A long wait with no load must keep both LEDs dark.

// File: rtl/errcode_flasher_pkg.sv
package errcode_flasher_pkg;

    localparam int CODE_W   = 32;
    localparam int STEP     = 2;
    localparam int IDX_W    = 4;
    localparam int PRESET_N = 9;
    localparam int PERIOD   = CODE_W / STEP;

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [IDX_W-1:0]  idx_t;

    typedef struct packed {
        logic  run;
        code_t pat;
        logic  red;
        logic  green;
    } core_state_t;

    function automatic code_t preset_code(input idx_t idx);
        code_t c;
        case (idx)
            idx_t'(1): c = 32'hffff_0000;
            idx_t'(2): c = 32'haaaa_5555;
            idx_t'(3): c = 32'haaaa_0000;
            idx_t'(4): c = 32'h0000_5555;
            idx_t'(5): c = 32'hffff_aaaa;
            idx_t'(6): c = 32'hffff_5555;
            idx_t'(7): c = 32'heeee_4444;
            idx_t'(8): c = 32'hdddd_8888;
            idx_t'(9): c = 32'hdddd_cccc;
            default:   c = '0;
        endcase
        return c;
    endfunction

    function automatic logic is_preset(input idx_t idx);
        return (idx >= idx_t'(1)) && (idx <= idx_t'(PRESET_N));
    endfunction

    function automatic code_t ror_step(input code_t v);
        return {v[STEP-1:0], v[CODE_W-1:STEP]};
    endfunction

endpackage

// File: rtl/errcode_flasher_tick.sv
module errcode_flasher_tick #(
    parameter int TICK_CYCLES = 12_500_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic run_i,
    output logic tick_o
);
    localparam int CNT_W = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TICK_CYCLES - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic             wrap;

    always_comb begin
        wrap  = (cnt_q == LAST);
        cnt_d = cnt_q;
        if (clear_i) begin
            cnt_d = '0;
        end else if (run_i) begin
            cnt_d = wrap ? '0 : cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign tick_o = run_i && wrap;

endmodule

// File: rtl/errcode_flasher_sel.sv
module errcode_flasher_sel
    import errcode_flasher_pkg::*;
#(
    parameter bit USE_PRESETS = 1'b1
) (
    input  idx_t  idx_i,
    input  code_t code_i,
    output code_t pat_o
);
    generate
        if (USE_PRESETS) begin : g_table
            always_comb begin
                pat_o = is_preset(idx_i) ? preset_code(idx_i) : code_i;
            end
        end else begin : g_raw
            logic unused_idx;
            assign unused_idx = ^idx_i;
            assign pat_o = code_i;
        end
    endgenerate

endmodule

// File: rtl/errcode_flasher_core.sv
module errcode_flasher_core
    import errcode_flasher_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  load_i,
    input  code_t pat_i,
    input  logic  tick_i,
    output logic  start_o,
    output logic  run_o,
    output code_t pat_o,
    output logic  red_o,
    output logic  green_o
);
    core_state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        start_o = load_i && !st_q.run;
        if (start_o) begin
            st_d.run = 1'b1;
            st_d.pat = pat_i;
        end else if (st_q.run && tick_i) begin
            st_d.green = st_q.pat[0];
            st_d.red   = st_q.pat[1];
            st_d.pat   = ror_step(st_q.pat);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign run_o   = st_q.run;
    assign pat_o   = st_q.pat;
    assign red_o   = st_q.red;
    assign green_o = st_q.green;

endmodule

// File: rtl/errcode_flasher.sv
module errcode_flasher
    import errcode_flasher_pkg::*;
#(
    parameter int TICK_CYCLES = 12_500_000,
    parameter bit USE_PRESETS = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load_i,
    input  logic [3:0]  err_idx_i,
    input  logic [31:0] code_i,
    output logic        led_red_o,
    output logic        led_green_o
);
    code_t sel_pat;
    code_t pat_w;
    logic  start_w;
    logic  run_w;
    logic  tick_w;

    errcode_flasher_sel #(
        .USE_PRESETS(USE_PRESETS)
    ) u_sel (
        .idx_i  (err_idx_i),
        .code_i (code_i),
        .pat_o  (sel_pat)
    );

    errcode_flasher_tick #(
        .TICK_CYCLES(TICK_CYCLES)
    ) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (start_w),
        .run_i   (run_w),
        .tick_o  (tick_w)
    );

    errcode_flasher_core u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load_i),
        .pat_i   (sel_pat),
        .tick_i  (tick_w),
        .start_o (start_w),
        .run_o   (run_w),
        .pat_o   (pat_w),
        .red_o   (led_red_o),
        .green_o (led_green_o)
    );

endmodule

// File: rtl/errcode_flasher_chk.sv
module errcode_flasher_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        run,
    input logic        tick,
    input logic [31:0] pat,
    input logic        red,
    input logic        green
);
    p_dark_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (!red && !green));

    p_run_sticks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> run);

    p_tick_needs_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> run);

    p_hold_between_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick) |=> ($stable(red) && $stable(green) && $stable(pat)));

    p_rotate_two_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (pat == {$past(pat[1:0]), $past(pat[31:2])}));

    p_led_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> ((green == $past(pat[0])) && (red == $past(pat[1]))));

endmodule

bind errcode_flasher errcode_flasher_chk u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run_w),
    .tick  (tick_w),
    .pat   (pat_w),
    .red   (led_red_o),
    .green (led_green_o)
);

// File: tb/errcode_flasher_tb.sv
module errcode_flasher_tb;
    localparam int TICK = 5;
    localparam logic [31:0] PRE [9] = '{
        32'hffff0000, 32'haaaa5555, 32'haaaa0000, 32'h00005555, 32'hffffaaaa,
        32'hffff5555, 32'heeee4444, 32'hdddd8888, 32'hddddcccc };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load = 1'b0;
    logic [3:0]  idx = 4'd0;
    logic [31:0] code = '0;
    logic        red, green;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    errcode_flasher #(.TICK_CYCLES(TICK)) u_dut (
        .clk(clk), .rst_n(rst_n), .load_i(load), .err_idx_i(idx),
        .code_i(code), .led_red_o(red), .led_green_o(green));

    // behavioural reference, updated on each edge
    bit          m_run;
    logic [31:0] m_word;
    int          m_cnt;
    bit          m_r, m_g;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_run = 0; m_word = '0; m_cnt = 0; m_r = 0; m_g = 0;
        end else if (!m_run) begin
            if (load) begin
                m_run = 1; m_cnt = 0;
                m_word = (idx >= 1 && idx <= 9) ? PRE[idx-1] : code;
            end
        end else begin
            if (m_cnt == TICK - 1) begin
                m_cnt = 0;
                m_g = m_word[0]; m_r = m_word[1];
                m_word = {m_word[1:0], m_word[31:2]};
            end else begin
                m_cnt++;
            end
        end
    end

    task automatic check(input string tag, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: leds {red,green} actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    // model comparison on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) check("R7 model", {red, green}, {m_r, m_g});
    end

    function automatic logic [1:0] pair_at(input logic [31:0] c, input int k);
        int b = (2 * k) % 32;
        return {c[b+1], c[b]};
    endfunction

    task automatic do_reset();
        rst_n = 1'b0; load = 1'b0;
        repeat (2) @(negedge clk);
        check("R1", {red, green}, 2'b00);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", {red, green}, 2'b00);
    endtask

    task automatic do_load(input logic [3:0] i, input logic [31:0] c);
        idx = i; code = c; load = 1'b1;
        @(negedge clk);
        load = 1'b0; idx = 4'd0; code = '0;
    endtask

    // follow steps k0..k0+n-1; the first wait already used 'skip' negedges
    task automatic follow(input string tag, input logic [31:0] c, input int k0,
                          input int n, input int skip);
        for (int k = k0; k < k0 + n; k++) begin
            logic [1:0] prev = (k == 0) ? 2'b00 : pair_at(c, k - 1);
            repeat (TICK - 1 - ((k == k0) ? skip : 0)) @(negedge clk);
            check("R7 hold", {red, green}, prev);
            @(negedge clk);
            check(tag, {red, green}, pair_at(c, k));
        end
    endtask

    initial begin
        do_reset();

        // R2: no load for many periods
        repeat (6 * TICK) @(negedge clk);
        check("R2", {red, green}, 2'b00);

        // R3, R5, R6: raw code, then R8 second lap
        do_load(4'd0, 32'h9c3e5a71);
        follow("R6", 32'h9c3e5a71, 0, 16, 0);
        follow("R8", 32'h9c3e5a71, 16, 16, 0);

        // R7: first step timing with low pair 11, R5 colour mapping
        do_reset();
        do_load(4'd13, 32'h0000_0007);
        repeat (TICK - 1) @(negedge clk);
        check("R7 first", {red, green}, 2'b00);
        @(negedge clk);
        check("R5", {red, green}, 2'b11);
        @(negedge clk);
        check("R7 hold", {red, green}, 2'b11);

        // R9: second load mid-run is ignored
        do_reset();
        do_load(4'd15, 32'h6b2d_e491);
        follow("R3", 32'h6b2d_e491, 0, 3, 0);
        idx = 4'd2; code = 32'h0; load = 1'b1;
        @(negedge clk);
        load = 1'b0; idx = 4'd0;
        follow("R9", 32'h6b2d_e491, 3, 16, 1);

        // R4: every built-in code, full two laps
        for (int p = 1; p <= 9; p++) begin
            do_reset();
            do_load(4'(p), 32'h1234_5678);
            follow("R4", PRE[p-1], 0, 32, 0);
        end

        // R2 again after a reset, with load never raised
        do_reset();
        repeat (4 * TICK) @(negedge clk);
        check("R2", {red, green}, 2'b00);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #2_000_000;
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule